// File: doc/BRIEF.md
# GPIO edge interrupt event unit

This unit watches 32 GPIO inputs, which reach it already synchronized to its clock, for transitions. Every qualifying transition latches a per-line event bit. The event bits are gated by a mask register and reduced to a single interrupt request. Software decides per line which transitions count, through one sense register or, in the two-bit variant, through two of them. Software clears an event by writing a one to its bit.

A parameter picks the sense variant. In the one-bit variant each line chooses falling-only or any-edge detection. In the two-bit variant each line carries a two-bit field, and the 32 fields are split over two registers. The block uses a simple 32-bit register bus: a write strobe, an address and write data. Reads are combinational from the address.

Top module: `gei_irq_unit`

## Requirements
- R1: After reset the event, mask and both sense registers read zero and `irq_o` is low.
- R2: An edge is found by comparing each input with its sample from the previous clock. The first sample after reset only sets the baseline and never creates an event. An event is readable in the cycle after the edge is sampled.
- R3: Line n maps to bit 31-n in both the event register and the mask register.
- R4: Writing the event register clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R5: If a qualifying edge and a write-one-to-clear hit the same event bit in the same cycle, the bit ends up set.
- R6: `irq_o` is high exactly when event AND mask is non-zero. Events latch even on masked lines. A write of all zeros to the mask makes `irq_o` low from the next cycle.
- R7: In one-bit mode (DUAL_SENSE=0), line n is controlled by bit 31-n of the sense register at 0x14. A value of 1 detects only falling edges and a value of 0 detects both edges.
- R8: In two-bit mode (DUAL_SENSE=1), lines 0 to 15 use the register at 0x14 and lines 16 to 31 use the register at 0x18. The field of line n starts at bit (15 - n mod 16)*2. Field codes: 2 selects falling, 1 selects rising, 0 selects both, and 3 disables detection.
- R9: Register map: event at 0x0c, mask at 0x10, sense at 0x14, second sense at 0x18. In one-bit mode 0x18 reads zero and ignores writes. Any other address reads zero.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | 32 | Synchronized GPIO inputs, bit n is line n |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions check several properties on every cycle. An event bit that was not cleared stays set. A bit that a detected edge hits is set in the next cycle, whatever the clear write in that cycle. No event bit appears without a detected edge. Zeroing the mask drops the interrupt. Only the bench scenarios can show the following: the bit-reversed line mapping, the field placement and code meanings of both sense variants, the baseline taken after reset, and the register read map.

// File: rtl/gei_pkg.sv
package gei_pkg;
    localparam int GEI_W    = 32;
    localparam int GEI_HALF = GEI_W / 2;

    localparam int OFS_EVT = 12;
    localparam int OFS_MSK = 16;
    localparam int OFS_CT0 = 20;
    localparam int OFS_CT1 = 24;

    typedef struct packed {
        logic [GEI_W-1:0] evt;
        logic [GEI_W-1:0] msk;
        logic [GEI_W-1:0] ct0;
        logic [GEI_W-1:0] ct1;
    } gei_regs_t;
endpackage

// File: rtl/gei_edge_detect.sv
module gei_edge_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] line_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic         armed;
    } ed_state_t;

    ed_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.prev  = line_i;
        st_d.armed = 1'b1;
        if (st_q.armed) begin
            rise_o = line_i & ~st_q.prev;
            fall_o = ~line_i & st_q.prev;
        end else begin
            rise_o = '0;
            fall_o = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/gei_sense_decode.sv
module gei_sense_decode #(
    parameter int W    = 32,
    parameter bit DUAL = 1'b0
) (
    input  logic [W-1:0] ct0_i,
    input  logic [W-1:0] ct1_i,
    output logic [W-1:0] rise_en_o,
    output logic [W-1:0] fall_en_o
);
    localparam int HALF = W / 2;

    if (DUAL) begin : g_two_bit
        for (genvar n = 0; n < W; n++) begin : g_line
            localparam int SH = (HALF - 1 - (n % HALF)) * 2;
            logic [1:0] fld;
            assign fld          = (n < HALF) ? ct0_i[SH +: 2] : ct1_i[SH +: 2];
            assign rise_en_o[n] = (fld == 2'd1) || (fld == 2'd0);
            assign fall_en_o[n] = (fld == 2'd2) || (fld == 2'd0);
        end
    end else begin : g_one_bit
        logic ct1_unused;
        assign ct1_unused = ^ct1_i;
        for (genvar n = 0; n < W; n++) begin : g_line
            assign fall_en_o[n] = 1'b1;
            assign rise_en_o[n] = ~ct0_i[W - 1 - n];
        end
    end
endmodule

// File: rtl/gei_irq_unit.sv
module gei_irq_unit
    import gei_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter bit DUAL_SENSE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GEI_W-1:0]  line_i,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [GEI_W-1:0]  bus_wdata,
    output logic [GEI_W-1:0]  bus_rdata,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] A_EVT = ADDR_W'(OFS_EVT);
    localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(OFS_MSK);
    localparam logic [ADDR_W-1:0] A_CT0 = ADDR_W'(OFS_CT0);
    localparam logic [ADDR_W-1:0] A_CT1 = ADDR_W'(OFS_CT1);

    gei_regs_t regs_d, regs_q;

    logic [GEI_W-1:0] rise, fall, rise_en, fall_en;
    logic [GEI_W-1:0] hit_bus;
    logic [GEI_W-1:0] clr_vec;

    gei_edge_detect #(.W(GEI_W)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    gei_sense_decode #(.W(GEI_W), .DUAL(DUAL_SENSE)) u_sense (
        .ct0_i     (regs_q.ct0),
        .ct1_i     (regs_q.ct1),
        .rise_en_o (rise_en),
        .fall_en_o (fall_en)
    );

    // line n lands on event bit W-1-n
    for (genvar n = 0; n < GEI_W; n++) begin : g_map
        assign hit_bus[GEI_W - 1 - n] = (rise[n] & rise_en[n]) | (fall[n] & fall_en[n]);
    end

    always_comb begin
        regs_d  = regs_q;
        clr_vec = (bus_we && bus_addr == A_EVT) ? bus_wdata : '0;
        // a fresh edge overrides a clear of the same bit
        regs_d.evt = (regs_q.evt & ~clr_vec) | hit_bus;
        if (bus_we) begin
            case (bus_addr)
                A_MSK: regs_d.msk = bus_wdata;
                A_CT0: regs_d.ct0 = bus_wdata;
                A_CT1: if (DUAL_SENSE) regs_d.ct1 = bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (bus_addr)
            A_EVT:   bus_rdata = regs_q.evt;
            A_MSK:   bus_rdata = regs_q.msk;
            A_CT0:   bus_rdata = regs_q.ct0;
            A_CT1:   bus_rdata = DUAL_SENSE ? regs_q.ct1 : '0;
            default: bus_rdata = '0;
        endcase
    end

    assign irq_o = |(regs_q.evt & regs_q.msk);

    // R4: an event that was not cleared survives
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((regs_q.evt & ~clr_vec) != '0) |=>
            ((regs_q.evt & $past(regs_q.evt & ~clr_vec)) == $past(regs_q.evt & ~clr_vec)));

    // R5: a detected edge sets its bit, even under a clear
    a_r5_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_bus != '0) |=> ((regs_q.evt & $past(hit_bus)) == $past(hit_bus)));

    // R2: no event bit appears without a detected edge
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((regs_q.evt & ~$past(regs_q.evt) & ~$past(hit_bus)) == '0));

    // R6: zeroing the mask silences the request
    a_r6_mask_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_MSK && bus_wdata == '0) |=> !irq_o);
endmodule

// File: tb/gei_irq_unit_test.sv
module gei_irq_unit_test;
    localparam logic [7:0] EVT = 8'h0c;
    localparam logic [7:0] MSK = 8'h10;
    localparam logic [7:0] CT0 = 8'h14;
    localparam logic [7:0] CT1 = 8'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lines = 32'h0000_00F0;
    logic        we0 = 1'b0, we1 = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rd0, rd1;
    logic        irq0, irq1;

    int errors = 0;
    int checks = 0;
    int issued = 0;
    int done_cnt = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    gei_irq_unit #(.ADDR_W(8), .DUAL_SENSE(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .line_i(lines), .bus_we(we0), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rd0), .irq_o(irq0));

    gei_irq_unit #(.ADDR_W(8), .DUAL_SENSE(1'b1)) uut_dual (
        .clk(clk), .rst_n(rst_n), .line_i(lines), .bus_we(we1), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rd1), .irq_o(irq1));

    typedef struct {
        bit          dual;
        logic [7:0]  a;
        logic [31:0] exp_rd;
        logic        exp_irq;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    // monitor: pops expectations and compares them with the live outputs
    initial begin
        forever begin
            sb_item_t it;
            logic [31:0] got;
            logic        gi;
            wait (sb_q.size() > 0);
            it   = sb_q.pop_front();
            addr = it.a;
            #1;
            got = it.dual ? rd1 : rd0;
            gi  = it.dual ? irq1 : irq0;
            checks++;
            if (got !== it.exp_rd || gi !== it.exp_irq) begin
                errors++;
                $display("FAIL %s: addr %h rdata %h irq %b, expected rdata %h irq %b",
                         it.tag, it.a, got, gi, it.exp_rd, it.exp_irq);
            end
            done_cnt++;
        end
    end

    task automatic expect_rd(input bit d, input logic [7:0] a, input logic [31:0] e,
                             input logic ei, input string tag);
        sb_item_t it;
        it.dual = d; it.a = a; it.exp_rd = e; it.exp_irq = ei; it.tag = tag;
        issued++;
        sb_q.push_back(it);
        wait (done_cnt == issued);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        we0 = sel[0]; we1 = sel[1]; addr = a; wdata = d;
        @(negedge clk);
        we0 = 1'b0; we1 = 1'b0;
    endtask

    task automatic drive_lines(input logic [31:0] v);
        @(negedge clk);
        lines = v;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        // R1 / R2: reset state, high lines at release give no event
        expect_rd(0, EVT, 32'h0, 1'b0, "R1 R2 event after reset");
        expect_rd(0, MSK, 32'h0, 1'b0, "R1 mask after reset");
        expect_rd(0, CT0, 32'h0, 1'b0, "R1 sense after reset");
        expect_rd(1, EVT, 32'h0, 1'b0, "R2 dual event after reset");
        expect_rd(1, CT1, 32'h0, 1'b0, "R1 dual second sense after reset");

        // R3 / R6: line 0 rises, lands on bit 31, latched while masked
        drive_lines(32'h0000_00F1);
        expect_rd(0, EVT, 32'h8000_0000, 1'b0, "R3 R6 line0 event masked");
        expect_rd(1, EVT, 32'h8000_0000, 1'b0, "R8 code0 both edges rise");

        wr(2'b01, MSK, 32'h8000_0000);
        expect_rd(0, MSK, 32'h8000_0000, 1'b1, "R6 unmask raises irq");

        // R4: write-one-to-clear
        wr(2'b01, EVT, 32'h7FFF_FFFF);
        expect_rd(0, EVT, 32'h8000_0000, 1'b1, "R4 zero bits keep event");
        wr(2'b11, EVT, 32'hFFFF_FFFF);
        expect_rd(0, EVT, 32'h0, 1'b0, "R4 one clears event");
        expect_rd(1, EVT, 32'h0, 1'b0, "R4 dual clear");

        // R7: line 1 falling only
        wr(2'b01, CT0, 32'h4000_0000);
        drive_lines(32'h0000_00F3);
        expect_rd(0, EVT, 32'h0, 1'b0, "R7 rise ignored on falling-only line");
        drive_lines(32'h0000_00F0);
        expect_rd(0, EVT, 32'hC000_0000, 1'b1, "R7 falls on both lines");

        // R5: edge and clear in the same cycle
        @(negedge clk);
        lines = 32'h0000_00F1; we0 = 1'b1; addr = EVT; wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        we0 = 1'b0;
        expect_rd(0, EVT, 32'h8000_0000, 1'b1, "R5 edge wins over clear");

        // R8: two-bit fields
        wr(2'b10, CT0, 32'h6C00_0000);
        wr(2'b10, CT1, 32'h8000_0001);
        wr(2'b10, EVT, 32'hFFFF_FFFF);
        expect_rd(1, CT0, 32'h6C00_0000, 1'b0, "R9 dual sense A readback");
        expect_rd(1, CT1, 32'h8000_0001, 1'b0, "R9 dual sense B readback");
        drive_lines(32'h8001_00F7);
        expect_rd(1, EVT, 32'h0000_0001, 1'b0, "R8 rises: only line31 rising");
        wr(2'b10, EVT, 32'hFFFF_FFFF);
        drive_lines(32'h0000_00F0);
        expect_rd(1, EVT, 32'h4000_8000, 1'b0, "R8 falls: lines 1 and 16, code3 silent");

        wr(2'b10, MSK, 32'h0000_8000);
        expect_rd(1, MSK, 32'h0000_8000, 1'b1, "R6 R3 line16 unmasked");
        wr(2'b10, MSK, 32'h0);
        expect_rd(1, EVT, 32'h4000_8000, 1'b0, "R6 mask zero drops irq");

        // R9: map corners in one-bit mode
        wr(2'b01, CT1, 32'hFFFF_FFFF);
        expect_rd(0, CT1, 32'h0, 1'b1, "R9 second sense absent in one-bit mode");
        expect_rd(0, 8'h00, 32'h0, 1'b1, "R9 unmapped address reads zero");
        expect_rd(0, CT0, 32'h4000_0000, 1'b1, "R9 sense readback");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule